// File: doc/BRIEF.md
# Power Mode Control State Machine

This block supervises the operating mode of a power-management device. It holds one of four modes: Standby, Normal, Sleep and Overtemperature. From that mode it drives the enables of two supply regulators, a mode code for each of two bus transceivers, a watchdog enable, an active-low system reset output and a limp-home flag. A host selects the mode through a 2-bit mode-control field. Bus and local wake events bring the device back from Sleep. A thermal input forces a protective shutdown, and a second thermal input releases it.

Sleep entry is guarded. A Sleep request is granted only when no interrupt is pending, no wake-up is pending, and at least one wake source is enabled. When any of these conditions fails, the mode does not change and the block issues a short reset pulse. Each return to Standby, whether after a wake-up or after a thermal shutdown, also issues a reset pulse. A configuration input selects whether that pulse is short or long. Both pulse lengths are cycle-count parameters.

All outputs are registered and change on the same clock edge as the mode register.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode is Standby (`mode`=00) and `mc_field`=00. The outputs are `v1_en`=1, `v2_en`=0, `can_mode`=`lin_mode`=01 (low power), `wd_en`=1, `rst_n`=1 and `limp`=0.
- R2: In Standby or Normal, a host write of 11 selects Normal and a write of 00 selects Standby. `mc_field` takes the written value. Normal gives `mode`=11, both regulators on and both transceivers at 10 (active). A write of 10 has no effect.
- R3: A host write of 01 in Standby or Normal enters Sleep (`mode`=01, `mc_field`=01) only if `irq_pend`=0, `wake_pend`=0 and `wake_en`≠000. In Sleep both regulators are off, `wd_en`=0 and `rst_n`=0.
- R4: A refused Sleep request leaves `mode` and `mc_field` unchanged. It drives `rst_n` low for exactly SHORT_RST_CYC cycles, starting in the cycle after the request.
- R5: In Sleep each transceiver code is 00 (off) when its standby-control input is 0, and 01 (low power with wake detection) when that input is 1.
- R6: In Sleep, a wake event on a source whose enable bit is set moves the mode to Standby. The `wake_en` and `wake_evt` bits are bit 0 CAN, bit 1 LIN and bit 2 local. On this move `mc_field` becomes 00 and `v1_en` becomes 1. `rst_n` stays low for SHORT_RST_CYC cycles when `long_rst`=0, or LONG_RST_CYC cycles when `long_rst`=1. Wake events on disabled sources are ignored, and host writes are ignored while in Sleep.
- R7: `otp_hot` in Standby or Normal enters Overtemperature (`mode`=10). This takes priority over a host write in the same cycle. In Overtemperature both regulators are off, both transceivers are 11 (high impedance), `rst_n`=0, `wd_en`=0 and `limp`=1. `otp_hot` has no effect in Sleep.
- R8: Overtemperature is left only when `otp_cool` is asserted. The mode then becomes Standby with `mc_field`=00, and a reset pulse follows whose length is set by `long_rst`, as in R6. Host writes are ignored in Overtemperature.
- R9: `limp` stays at 1 after Overtemperature is left, until `limp_clr` is asserted outside Overtemperature. `limp_clr` has no effect while in Overtemperature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_wr | input | 1 | Host write strobe for the mode-control field |
| mc_wdata | input | 2 | Written mode code: 00 Standby, 01 Sleep, 11 Normal |
| irq_pend | input | 1 | An interrupt is pending |
| wake_pend | input | 1 | A wake-up event is pending |
| wake_en | input | 3 | Wake source enables (bit 0 CAN, 1 LIN, 2 local) |
| wake_evt | input | 3 | Wake events, same bit order as `wake_en` |
| can_stby_cfg | input | 1 | CAN transceiver low-power select for Sleep |
| lin_stby_cfg | input | 1 | LIN transceiver low-power select for Sleep |
| otp_hot | input | 1 | Over-temperature detected |
| otp_cool | input | 1 | Temperature has fallen below the hysteresis level |
| long_rst | input | 1 | Selects the long pulse for wake and thermal-exit resets |
| limp_clr | input | 1 | Host clear of the limp-home flag |
| mode | output | 2 | Current mode: 00 Standby, 01 Sleep, 10 Overtemp, 11 Normal |
| mc_field | output | 2 | Read-back of the mode-control field |
| v1_en | output | 1 | First regulator enable |
| v2_en | output | 1 | Second regulator enable |
| can_mode | output | 2 | CAN transceiver: 00 off, 01 low power, 10 active, 11 high-Z |
| lin_mode | output | 2 | LIN transceiver, same coding as `can_mode` |
| wd_en | output | 1 | Watchdog enable |
| rst_n | output | 1 | Active-low system reset output |
| limp | output | 1 | Limp-home flag |

## Verification
The hardest case to reach is the boundary between a granted and a refused Sleep request. The guard depends on five inputs, and both outcomes finish with `rst_n` low, so they can only be told apart by the mode code and by whether the low phase ends. The bench sweeps all 32 combinations of the interrupt, pending and enable inputs from Standby. For each granted case it wakes the block through exactly the enabled sources and counts the length of the reset pulse at the ports. For each refused case it counts the short pulse directly.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    M_STBY  = 2'b00,
    M_SLEEP = 2'b01,
    M_OTEMP = 2'b10,
    M_NORM  = 2'b11
  } pmc_mode_e;

  typedef enum logic [1:0] {
    X_OFF  = 2'b00,
    X_LOWP = 2'b01,
    X_ACT  = 2'b10,
    X_HIZ  = 2'b11
  } pmc_xcvr_e;

  localparam int NUM_WAKE = 3;
endpackage

// File: rtl/pmc_sleep_guard.sv
module pmc_sleep_guard #(
  parameter int NW = 3
) (
  input  logic          irq_pend,
  input  logic          wake_pend,
  input  logic [NW-1:0] wake_en,
  output logic          sleep_ok
);
  always_comb sleep_ok = !irq_pend && !wake_pend && (|wake_en);
endmodule

// File: rtl/pmc_rst_timer.sv
module pmc_rst_timer #(
  parameter int SHORT_CYC = 8,
  parameter int LONG_CYC  = 24,
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_short,
  input  logic load_long,
  output logic pulse_next
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_long)        cnt_d = CW'(LONG_CYC);
    else if (load_short)  cnt_d = CW'(SHORT_CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = '0;
    pulse_next = (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assert_pulse_countdown_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !load_short && !load_long) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pmc_out_stage.sv
module pmc_out_stage
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pmc_mode_e nxt_mode,
  input  logic      can_cfg,
  input  logic      lin_cfg,
  input  logic      pulse_next,
  output logic      v1_en,
  output logic      v2_en,
  output logic [1:0] can_mode,
  output logic [1:0] lin_mode,
  output logic      wd_en,
  output logic      rst_n
);
  function automatic pmc_xcvr_e xcvr_code(pmc_mode_e m, logic cfg);
    case (m)
      M_NORM:  return X_ACT;
      M_SLEEP: return cfg ? X_LOWP : X_OFF;
      M_OTEMP: return X_HIZ;
      default: return X_LOWP;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_en    <= 1'b1;
      v2_en    <= 1'b0;
      can_mode <= X_LOWP;
      lin_mode <= X_LOWP;
      wd_en    <= 1'b1;
      rst_n    <= 1'b1;
    end else begin
      v1_en    <= (nxt_mode == M_STBY) || (nxt_mode == M_NORM);
      v2_en    <= (nxt_mode == M_NORM);
      can_mode <= xcvr_code(nxt_mode, can_cfg);
      lin_mode <= xcvr_code(nxt_mode, lin_cfg);
      wd_en    <= (nxt_mode == M_STBY) || (nxt_mode == M_NORM);
      rst_n    <= !((nxt_mode == M_SLEEP) || (nxt_mode == M_OTEMP) || pulse_next);
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SHORT_RST_CYC = 8,
  parameter int LONG_RST_CYC  = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mc_wr,
  input  logic [1:0] mc_wdata,
  input  logic       irq_pend,
  input  logic       wake_pend,
  input  logic [2:0] wake_en,
  input  logic [2:0] wake_evt,
  input  logic       can_stby_cfg,
  input  logic       lin_stby_cfg,
  input  logic       otp_hot,
  input  logic       otp_cool,
  input  logic       long_rst,
  input  logic       limp_clr,
  output logic [1:0] mode,
  output logic [1:0] mc_field,
  output logic       v1_en,
  output logic       v2_en,
  output logic [1:0] can_mode,
  output logic [1:0] lin_mode,
  output logic       wd_en,
  output logic       rst_n,
  output logic       limp
);
  pmc_mode_e  mode_q, mode_d;
  logic [1:0] mc_q, mc_d;
  logic       limp_q, limp_d;
  logic       sleep_ok, ld_short, ld_long, pulse_next;
  logic       awake;

  pmc_sleep_guard #(.NW(NUM_WAKE)) guard_i (
    .irq_pend (irq_pend),
    .wake_pend(wake_pend),
    .wake_en  (wake_en),
    .sleep_ok (sleep_ok)
  );

  assign awake = |(wake_evt & wake_en);

  always_comb begin
    mode_d   = mode_q;
    mc_d     = mc_q;
    ld_short = 1'b0;
    ld_long  = 1'b0;
    case (mode_q)
      M_STBY, M_NORM: begin
        if (otp_hot) begin
          mode_d = M_OTEMP;
        end else if (mc_wr) begin
          case (mc_wdata)
            2'b00: begin mode_d = M_STBY; mc_d = 2'b00; end
            2'b11: begin mode_d = M_NORM; mc_d = 2'b11; end
            2'b01: begin
              if (sleep_ok) begin mode_d = M_SLEEP; mc_d = 2'b01; end
              else          ld_short = 1'b1;
            end
            default: ;
          endcase
        end
      end
      M_SLEEP: begin
        if (awake) begin
          mode_d   = M_STBY;
          mc_d     = 2'b00;
          ld_long  = long_rst;
          ld_short = !long_rst;
        end
      end
      default: begin
        if (otp_cool) begin
          mode_d   = M_STBY;
          mc_d     = 2'b00;
          ld_long  = long_rst;
          ld_short = !long_rst;
        end
      end
    endcase
    if (mode_d == M_OTEMP)  limp_d = 1'b1;
    else if (limp_clr)      limp_d = 1'b0;
    else                    limp_d = limp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_STBY;
      mc_q   <= 2'b00;
      limp_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      mc_q   <= mc_d;
      limp_q <= limp_d;
    end
  end

  pmc_rst_timer #(.SHORT_CYC(SHORT_RST_CYC), .LONG_CYC(LONG_RST_CYC)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .load_short(ld_short),
    .load_long (ld_long),
    .pulse_next(pulse_next)
  );

  pmc_out_stage out_i (
    .clk       (clk),
    .rst       (rst),
    .nxt_mode  (mode_d),
    .can_cfg   (can_stby_cfg),
    .lin_cfg   (lin_stby_cfg),
    .pulse_next(pulse_next),
    .v1_en     (v1_en),
    .v2_en     (v2_en),
    .can_mode  (can_mode),
    .lin_mode  (lin_mode),
    .wd_en     (wd_en),
    .rst_n     (rst_n)
  );

  assign mode     = mode_q;
  assign mc_field = mc_q;
  assign limp     = limp_q;

  assert_sleep_rails_off_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SLEEP) |-> (!v1_en && !v2_en && !wd_en && !rst_n));

  assert_refused_stays_R4: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_STBY || mode_q == M_NORM) && mc_wr && mc_wdata == 2'b01 &&
     !sleep_ok && !otp_hot) |=> (mode_q == $past(mode_q) && !rst_n));

  assert_wake_to_standby_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SLEEP && awake) |=> (mode_q == M_STBY && mc_q == 2'b00 && v1_en));

  assert_otemp_safe_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_OTEMP) |-> (limp_q && !rst_n && !v1_en && !v2_en));

  assert_otemp_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_OTEMP && !otp_cool) |=> (mode_q == M_OTEMP));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT = 8;
  localparam int LONG  = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc_wr = 1'b0;
  logic [1:0] mc_wdata = 2'b00;
  logic irq_pend = 1'b0, wake_pend = 1'b0;
  logic [2:0] wake_en = 3'b000, wake_evt = 3'b000;
  logic can_stby_cfg = 1'b0, lin_stby_cfg = 1'b0;
  logic otp_hot = 1'b0, otp_cool = 1'b0, long_rst = 1'b0, limp_clr = 1'b0;
  logic [1:0] mode, mc_field, can_mode, lin_mode;
  logic v1_en, v2_en, wd_en, rst_n, limp;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.SHORT_RST_CYC(SHORT), .LONG_RST_CYC(LONG)) dut_i (
    .clk(clk), .rst(rst), .mc_wr(mc_wr), .mc_wdata(mc_wdata),
    .irq_pend(irq_pend), .wake_pend(wake_pend), .wake_en(wake_en),
    .wake_evt(wake_evt), .can_stby_cfg(can_stby_cfg), .lin_stby_cfg(lin_stby_cfg),
    .otp_hot(otp_hot), .otp_cool(otp_cool), .long_rst(long_rst), .limp_clr(limp_clr),
    .mode(mode), .mc_field(mc_field), .v1_en(v1_en), .v2_en(v2_en),
    .can_mode(can_mode), .lin_mode(lin_mode), .wd_en(wd_en), .rst_n(rst_n), .limp(limp)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [1:0] v);
    mc_wr = 1'b1; mc_wdata = v;
    tick();
    mc_wr = 1'b0;
  endtask

  task automatic measure_pulse(output int n);
    n = 0;
    while (rst_n == 1'b0 && n < 200) begin
      n++;
      tick();
    end
  endtask

  task automatic wake(logic [2:0] ev);
    wake_evt = ev;
    tick();
    wake_evt = 3'b000;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 mode", mode, 0);       chk("R1 mc_field", mc_field, 0);
    chk("R1 v1_en", v1_en, 1);     chk("R1 v2_en", v2_en, 0);
    chk("R1 can_mode", can_mode, 1); chk("R1 lin_mode", lin_mode, 1);
    chk("R1 wd_en", wd_en, 1);     chk("R1 rst_n", rst_n, 1);
    chk("R1 limp", limp, 0);

    // R2 Normal / Standby selection, code 10 ignored
    host_write(2'b11);
    chk("R2 mode normal", mode, 3); chk("R2 mc normal", mc_field, 3);
    chk("R2 v2_en", v2_en, 1);      chk("R2 can active", can_mode, 2);
    chk("R2 lin active", lin_mode, 2); chk("R2 rst_n", rst_n, 1);
    host_write(2'b10);
    chk("R2 code10 ignored mode", mode, 3); chk("R2 code10 ignored mc", mc_field, 3);
    host_write(2'b00);
    chk("R2 mode standby", mode, 0); chk("R2 v2 off", v2_en, 0);

    // R3/R4/R6 guard sweep from Standby
    for (int i = 0; i < 32; i++) begin
      bit ok;
      irq_pend = i[4]; wake_pend = i[3]; wake_en = i[2:0];
      ok = (i[4] == 1'b0) && (i[3] == 1'b0) && (i[2:0] != 3'b000);
      host_write(2'b01);
      if (ok) begin
        chk("R3 sleep mode", mode, 1); chk("R3 sleep mc", mc_field, 1);
        chk("R3 v1 off", v1_en, 0);    chk("R3 wd off", wd_en, 0);
        chk("R3 rst_n low", rst_n, 0);
        irq_pend = 1'b0; wake_pend = 1'b0;
        wake(i[2:0]);
        chk("R6 wake mode", mode, 0); chk("R6 wake mc", mc_field, 0);
        chk("R6 wake v1", v1_en, 1);
        measure_pulse(n);
        chk("R6 short pulse", n, SHORT);
      end else begin
        chk("R4 refused mode", mode, 0); chk("R4 refused mc", mc_field, 0);
        measure_pulse(n);
        chk("R4 short pulse", n, SHORT);
      end
    end

    // R4 refused from Normal
    irq_pend = 1'b0; wake_pend = 1'b0; wake_en = 3'b001;
    host_write(2'b11);
    irq_pend = 1'b1;
    host_write(2'b01);
    chk("R4 refused normal mode", mode, 3); chk("R4 refused normal mc", mc_field, 3);
    measure_pulse(n);
    chk("R4 refused normal pulse", n, SHORT);
    irq_pend = 1'b0;

    // R5 transceiver sleep codes, R6 ignores, long pulse; enter from Normal
    for (int c = 0; c < 4; c++) begin
      can_stby_cfg = c[0]; lin_stby_cfg = c[1]; wake_en = 3'b100;
      host_write(2'b11);
      host_write(2'b01);
      chk("R5 sleep from normal", mode, 1);
      chk("R5 can code", can_mode, c[0] ? 1 : 0);
      chk("R5 lin code", lin_mode, c[1] ? 1 : 0);
      wake(3'b011);
      chk("R6 disabled wake ignored", mode, 1);
      host_write(2'b11);
      chk("R6 write in sleep ignored", mode, 1);
      chk("R6 write in sleep mc", mc_field, 1);
      otp_hot = 1'b1; tick(); otp_hot = 1'b0;
      chk("R7 hot in sleep ignored", mode, 1);
      long_rst = c[0];
      wake(3'b100);
      chk("R6 wake standby", mode, 0);
      measure_pulse(n);
      chk("R6 selected pulse", n, c[0] ? LONG : SHORT);
      long_rst = 1'b0;
    end

    // R7/R8/R9 over-temperature from Normal with a same-cycle write
    host_write(2'b11);
    otp_hot = 1'b1; mc_wr = 1'b1; mc_wdata = 2'b00;
    tick();
    otp_hot = 1'b0; mc_wr = 1'b0;
    chk("R7 priority otemp", mode, 2);
    chk("R7 v1 off", v1_en, 0);  chk("R7 v2 off", v2_en, 0);
    chk("R7 can hiz", can_mode, 3); chk("R7 lin hiz", lin_mode, 3);
    chk("R7 rst_n", rst_n, 0);   chk("R7 wd off", wd_en, 0);
    chk("R7 limp", limp, 1);
    tick();
    chk("R8 stays without cool", mode, 2);
    host_write(2'b11);
    chk("R8 write ignored", mode, 2);
    limp_clr = 1'b1; tick(); limp_clr = 1'b0;
    chk("R9 clear ignored in otemp", limp, 1);
    otp_cool = 1'b1; tick(); otp_cool = 1'b0;
    chk("R8 exit standby", mode, 0); chk("R8 exit mc", mc_field, 0);
    measure_pulse(n);
    chk("R8 short exit pulse", n, SHORT);
    chk("R9 limp held", limp, 1);
    limp_clr = 1'b1; tick(); limp_clr = 1'b0;
    chk("R9 limp cleared", limp, 0);

    // R7/R8 from Standby with long pulse
    otp_hot = 1'b1; tick(); otp_hot = 1'b0;
    chk("R7 otemp from standby", mode, 2);
    long_rst = 1'b1;
    otp_cool = 1'b1; tick(); otp_cool = 1'b0;
    chk("R8 exit from standby path", mode, 0);
    measure_pulse(n);
    chk("R8 long exit pulse", n, LONG);
    long_rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule